// File: doc/BRIEF.md
# Spike-Coded Threshold Gate (NAND / NOR)

This block models a small spiking network that behaves as an n-input Boolean gate. Every input channel and the output carry one symbol per clock: idle, spike (logic 1) or anti-spike (logic 0). Each input feeds its own relay stage, which turns the symbol into a number of spikes for a shared output neuron: two for a spike, one for an anti-spike, none for an idle slot. The output neuron adds up the spikes it receives on a step and applies a count-based firing table.

A parameter chooses the table. In NAND mode only the full count of 2n fires an anti-spike, and any count from n to 2n-1 fires a spike. In NOR mode only the count n (every input an anti-spike) fires a spike, and any higher count fires an anti-spike. A count below n fires nothing and is discarded. The pipeline accepts a new input set every clock, so independent evaluations overlap, and each result appears three clock edges after its inputs are sampled.

Top module: `spk_gate`

## Requirements
- R1: Symbols are coded in 2 bits: 2'b00 idle, 2'b01 spike (logic 1), 2'b10 anti-spike (logic 0). An input of 2'b11 counts as idle, and the output never carries 2'b11.
- R2: An input set sampled on rising edge k produces its output symbol on the output after rising edge k+2 (three register stages). No other input set affects that output slot.
- R3: Each input adds to the output neuron's count: 2 for a spike, 1 for an anti-spike, 0 for idle or 2'b11.
- R4: In NAND mode (NOR_MODE=0), a count of exactly 2n gives an anti-spike (2'b10), and a count from n to 2n-1 gives a spike (2'b01).
- R5: In NOR mode (NOR_MODE=1), a count of exactly n gives a spike (2'b01), and a count from n+1 to 2n gives an anti-spike (2'b10).
- R6: A count below n gives an idle output (2'b00) in both modes.
- R7: A new input set may be applied on every clock. Back-to-back sets give back-to-back results with no interaction.
- R8: While rst_n is low the output is idle (2'b00) whatever the inputs are, and the pipeline holds no pending evaluation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Global step clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_sym | input | 2*N_IN | Input symbols, channel i in bits [2i+1:2i] |
| out_sym | output | 2 | Output symbol fired by the output neuron |

## Verification
A relay that stores the wrong charge, or an adder that loses a term, moves the count across a rule boundary. This shows up as a flipped or missing output symbol exactly three edges after the input set that caused it. The full sweep of every symbol combination, run back to back, therefore ties each wrong output to one input set. A stage that is skipped or doubled shifts the whole result stream by a cycle, so the comparisons fail from the first evaluation onward. A NAND DUT and a NOR DUT run side by side on the same stimulus, which exposes a table that is wrong in either mode.

// File: rtl/spk_pkg.sv
package spk_pkg;

  typedef enum logic [1:0] {
    SYM_IDLE  = 2'b00,
    SYM_SPIKE = 2'b01,
    SYM_ANTI  = 2'b10,
    SYM_BAD   = 2'b11
  } sym_t;

  // spikes a relay delivers for one input symbol
  function automatic logic [1:0] relay_charge(logic [1:0] s);
    case (s)
      SYM_SPIKE: relay_charge = 2'd2;
      SYM_ANTI:  relay_charge = 2'd1;
      default:   relay_charge = 2'd0;
    endcase
  endfunction

  // count-based firing table of the output neuron
  function automatic logic [1:0] fire_rule(int unsigned cnt, int unsigned n, bit nor_mode);
    if (cnt < n || cnt > 2 * n) fire_rule = SYM_IDLE;
    else if (nor_mode)          fire_rule = (cnt == n) ? SYM_SPIKE : SYM_ANTI;
    else                        fire_rule = (cnt == 2 * n) ? SYM_ANTI : SYM_SPIKE;
  endfunction

endpackage

// File: rtl/spk_relay.sv
module spk_relay
  import spk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sym_i,
  output logic [1:0] charge_o
);
  logic [1:0] sym_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_q    <= SYM_IDLE;
      charge_o <= 2'd0;
    end else begin
      sym_q    <= sym_i;
      charge_o <= relay_charge(sym_q);
    end
  end

  // R3: a double charge can only come from a spike two edges earlier
  p_double_from_spike_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (charge_o == 2'd2) |-> ($past(sym_i, 2) == SYM_SPIKE));

  // R3: a single charge can only come from an anti-spike two edges earlier
  p_single_from_anti_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (charge_o == 2'd1) |-> ($past(sym_i, 2) == SYM_ANTI));

  p_charge_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    charge_o != 2'd3);
endmodule

// File: rtl/spk_out_neuron.sv
module spk_out_neuron
  import spk_pkg::*;
#(
  parameter int unsigned N_IN     = 2,
  parameter bit          NOR_MODE = 1'b0,
  localparam int unsigned CW      = $clog2(2 * N_IN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*N_IN-1:0] charge_i,
  output logic [1:0]        out_sym
);
  logic [CW-1:0] spike_sum;
  logic [1:0]    fire_sym;
  logic          fire_now;

  always_comb begin
    spike_sum = '0;
    for (int i = 0; i < int'(N_IN); i++)
      spike_sum = spike_sum + CW'(charge_i[2*i +: 2]);
  end

  assign fire_sym = fire_rule(32'(spike_sum), N_IN, NOR_MODE);
  assign fire_now = (fire_sym != SYM_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_sym <= SYM_IDLE;
    else        out_sym <= fire_now ? fire_sym : SYM_IDLE;
  end

  p_no_bad_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_sym != SYM_BAD);

  p_fire_needs_quorum_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sym != SYM_IDLE) |-> (32'($past(spike_sum)) >= N_IN));

  generate
    if (NOR_MODE) begin : g_nor
      p_nor_spike_only_at_n_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sym == SYM_SPIKE) |-> (32'($past(spike_sum)) == N_IN));
    end else begin : g_nand
      p_nand_anti_only_at_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sym == SYM_ANTI) |-> (32'($past(spike_sum)) == 2 * N_IN));
    end
  endgenerate
endmodule

// File: rtl/spk_gate.sv
module spk_gate
  import spk_pkg::*;
#(
  parameter int unsigned N_IN     = 2,
  parameter bit          NOR_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*N_IN-1:0] in_sym,
  output logic [1:0]        out_sym
);
  logic [2*N_IN-1:0] relay_charge_w;

  generate
    for (genvar g = 0; g < int'(N_IN); g++) begin : g_relay
      spk_relay u_relay (
        .clk      (clk),
        .rst_n    (rst_n),
        .sym_i    (in_sym[2*g +: 2]),
        .charge_o (relay_charge_w[2*g +: 2])
      );
    end
  endgenerate

  spk_out_neuron #(.N_IN(N_IN), .NOR_MODE(NOR_MODE)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .charge_i (relay_charge_w),
    .out_sym  (out_sym)
  );

  // R8: the first result after reset cannot be a firing
  p_idle_after_reset_r8: assert property (@(posedge clk)
    $rose(rst_n) |-> (out_sym == SYM_IDLE));
endmodule

// File: tb/spk_gate_tb.sv
module spk_gate_tb;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2*N-1:0] in_sym = '0;
  logic [1:0] out_nand, out_nor;

  always #4 clk = ~clk;

  spk_gate #(.N_IN(N), .NOR_MODE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_sym(in_sym), .out_sym(out_nand));
  spk_gate #(.N_IN(N), .NOR_MODE(1'b1)) u_nor (
    .clk(clk), .rst_n(rst_n), .in_sym(in_sym), .out_sym(out_nor));

  int ecnt = 0;
  always @(posedge clk) ecnt <= ecnt + 1;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    int         due;
    int         cnt;
    logic [1:0] e_nand;
    logic [1:0] e_nor;
  } item_t;
  item_t sb[$];

  function automatic int weight(logic [1:0] s);
    if (s == 2'b01) return 2;
    if (s == 2'b10) return 1;
    return 0;
  endfunction

  function automatic logic [1:0] nand_ref(int c);
    if (c < N) return 2'b00;
    if (c == 2 * N) return 2'b10;
    return 2'b01;
  endfunction

  function automatic logic [1:0] nor_ref(int c);
    if (c < N) return 2'b00;
    if (c == N) return 2'b01;
    return 2'b10;
  endfunction

  task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at edge %0d", tag, act, exp, ecnt);
    end
  endtask

  task automatic drive(logic [2*N-1:0] v);
    item_t it;
    int c;
    @(posedge clk);
    #2;
    in_sym = v;
    c = 0;
    for (int i = 0; i < N; i++) c += weight(v[2*i +: 2]);
    it.due = ecnt + 3;
    it.cnt = c;
    it.e_nand = nand_ref(c);
    it.e_nor = nor_ref(c);
    sb.push_back(it);
  endtask

  // monitor: pops scoreboard items when due
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].due == ecnt) begin
      item_t it;
      it = sb.pop_front();
      if (it.cnt < N) begin
        check("R6 idle nand (R1 R2 R3 R7)", out_nand, it.e_nand);
        check("R6 idle nor (R1 R2 R3 R7)", out_nor, it.e_nor);
      end else begin
        check("R4 nand table (R2 R3 R7)", out_nand, it.e_nand);
        check("R5 nor table (R2 R3 R7)", out_nor, it.e_nor);
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    // R8: inputs all spikes during reset must not fire
    in_sym = {N{2'b01}};
    repeat (4) @(negedge clk);
    check("R8 reset nand", out_nand, 2'b00);
    check("R8 reset nor", out_nor, 2'b00);
    in_sym = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 post-reset nand", out_nand, 2'b00);
    check("R8 post-reset nor", out_nor, 2'b00);

    // full sweep of every 3-channel symbol set, back to back
    for (int v = 0; v < 64; v++) drive((2*N)'(v));
    // a few hand-picked sets after an idle gap
    drive('0);
    drive({2'b01, 2'b01, 2'b01});
    drive({2'b10, 2'b10, 2'b10});
    drive({2'b01, 2'b01, 2'b00});
    drive({2'b11, 2'b01, 2'b10});
    drive('0);
    repeat (6) @(negedge clk);

    // R2: with idle inputs and an empty scoreboard nothing fires
    check("R2 quiet nand", out_nand, 2'b00);
    check("R2 quiet nor", out_nor, 2'b00);
    if (sb.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL R2: actual %0d pending expected 0", sb.size());
    end
    finish_run();
  end
endmodule